// File: doc/BRIEF.md
# Interruptible Multi-Register Transfer Sequencer

This block carries out a multi-register load or store as a chain of single-word bus accesses. The caller supplies a base byte address, a 16-bit mask that selects registers, a direction and a writeback flag. It then pulses `start_i`. The registers whose mask bits are set move one word at a time between the register file and consecutive words of memory.

Between two word accesses the sequencer may give way to a pending interrupt. There are two ways it can do this. In continuation mode it records the index of the next register still to be moved, so that a later restart with `resume_i` picks up where it stopped. In restart mode it records nothing, and a later start runs the whole list again. A memory fault ends the operation and leaves the base register unchanged, so the whole operation can be replayed.

A one-bit control register decides whether the sequencer may be interrupted at all. While that bit is set, every operation runs to its end before an interrupt is acknowledged. Only privileged writes change the bit.

Top module: `mreg_xfer_seq`

## Requirements
- R1: The k-th set bit of the mask, counting upward from register 0, is transferred at byte address base + 4*k. Each request holds its address stable until `mem_rdy_i` is seen.
- R2: A load writes each returned word into the register file at that register's index. A store reads the register at that index and drives its value onto `mem_wdata_o`, with `mem_we_o` high.
- R3: With the disable bit clear, an `irq_req_i` seen at a word boundary while more registers remain ends the sequence. In that cycle `brk_o` and `irq_ack_o` are both high. In the next cycle `busy_o` is low, and `done_o` is not raised for that sequence.
- R4: In continuation mode a break sets `cont_vld_o` and loads `cont_idx_o` with the next untransferred register. A start with `resume_i` high then moves only that register and the higher set ones, at base + 4 * (number of set bits below that index).
- R5: In restart mode a break leaves `cont_vld_o` low. A later start, even with `resume_i` high, transfers the list from its lowest set bit at the base address.
- R6: A word answered with `mem_err_i` raises `fault_o`, ends the sequence with `busy_o` low on the next cycle, and clears any continuation state. The base register is not written, and a faulting store does not change memory.
- R7: After the last word completes without fault and `wb_en_i` was set, the register `base_reg_i` receives base + 4 * (number of set mask bits). With `wb_en_i` clear it is left unchanged.
- R8: While bit 0 of the control register is 1, `irq_ack_o` stays low for as long as `busy_o` is high, and the sequence runs to `done_o`. Once the sequencer is idle, a pending request is acknowledged.
- R9: The control register resets to 0. A write with `ctl_priv_i` high at address 0xE000E008 loads bit 0 from `ctl_wdata_i[0]`. Unprivileged writes and writes to other addresses are ignored. A privileged read at that address returns the bit in position 0, with zeros in all other bits.
- R10: `irq_ack_o` is never high in a cycle where `mem_req_o` is high.
- R11: `done_o` is a single-cycle pulse that never coincides with `brk_o` or `fault_o`.
- R12: An all-zero mask makes no memory access. It finishes with `done_o`, and writes back the unchanged base if `wb_en_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sequence (taken when idle and no interrupt pending) |
| resume_i | input | 1 | Start from saved continuation state if it is valid |
| cont_mode_i | input | 1 | 1 = keep continuation on break, 0 = restart on break |
| is_load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| wb_en_i | input | 1 | Update the base register after success |
| base_i | input | 32 | Base byte address |
| mask_i | input | 16 | Register selection mask |
| base_reg_i | input | 4 | Index of the base register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Fault abort pulse |
| brk_o | output | 1 | Interrupt break pulse |
| cont_vld_o | output | 1 | Continuation state held |
| cont_idx_o | output | 4 | Next register to transfer on resume |
| mem_req_o | output | 1 | Word access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data |
| mem_rdy_i | input | 1 | Access completes this cycle |
| mem_err_i | input | 1 | Access faulted (valid with ready) |
| rf_raddr_o | output | 4 | Register read index for stores |
| rf_rdata_i | input | 32 | Register read data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 4 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| irq_req_i | input | 1 | Interrupt pending |
| irq_ack_o | output | 1 | Interrupt accepted |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_priv_i | input | 1 | Access is privileged |
| ctl_addr_i | input | 32 | Control access address |
| ctl_wdata_i | input | 32 | Control write data |
| ctl_rdata_o | output | 32 | Control read data |

## Verification
Some properties are checked on every cycle: an acknowledge is never raised during a bus request, a stalled request keeps its address, completion never coincides with a break or a fault, a break or fault leaves the block idle on the next cycle, and the disable bit blocks acknowledge while busy. Other behaviour can only be shown by the bench's scenarios. These are the exact order of addresses and data, the register chosen for continuation and the resumed address arithmetic, the replay from the first register in restart mode, an unchanged base after a fault, and the privilege filtering of the control register.

// File: rtl/mxs_pkg.sv
// Package: shared types for the multi-register transfer sequencer.
// Assumes: nothing beyond the standard language.
package mxs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for start
        ST_BOUND = 2'd1,  // word boundary: decide next step
        ST_BUS   = 2'd2,  // one word access outstanding
        ST_WRB   = 2'd3   // base register update
    } mxs_state_e;
endpackage

// File: rtl/mxs_find_next.sv
// Module: finds the lowest set mask bit at or above a start position.
// Assumes: from may equal NREG, in which case nothing is found.
module mxs_find_next #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG),
    parameter int PW   = IW + 1
) (
    input  logic [NREG-1:0] mask,
    input  logic [PW-1:0]   from,
    output logic [IW-1:0]   idx,
    output logic            found
);
    // priority scan from the top so the lowest qualifying bit wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mxs_count_below.sv
// Module: counts set mask bits strictly below a limit index.
// Assumes: the result fits in PW bits (NREG < 2**PW).
module mxs_count_below #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG),
    parameter int PW   = IW + 1
) (
    input  logic [NREG-1:0] mask,
    input  logic [PW-1:0]   lim,
    output logic [PW-1:0]   cnt
);
    // population count of the masked low part
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            if (mask[i] && (i < int'(lim))) begin
                cnt = cnt + PW'(1);
            end
        end
    end
endmodule

// File: rtl/mxs_ctl_reg.sv
// Module: one-bit control register that disables interruption of sequences.
// Assumes: privilege is qualified by the caller through ctl_priv; only
// bit 0 is stored and all other read bits return zero.
module mxs_ctl_reg #(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] CTL_ADDR = 32'hE000_E008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          priv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          dis
);
    logic hit;
    logic ctl_unused_bits;

    assign hit             = priv && (addr == AW'(CTL_ADDR));
    assign ctl_unused_bits = ^wdata[DW-1:1];

    // hold the disable bit; privileged writes at the mapped address only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis <= 1'b0;
        end else if (we && hit) begin
            dis <= wdata[0];
        end
    end

    // read port: privileged access at the mapped address sees bit 0
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = {{(DW-1){1'b0}}, dis};
        end
    end
endmodule

// File: rtl/mreg_xfer_seq.sv
// Module: interruptible multi-register load/store sequencer (top).
// Moves the registers selected by a mask, one word per bus access, in
// ascending register order to ascending addresses. At each word boundary
// a pending interrupt may break the sequence unless the control register
// disables this. Base writeback happens only after full success.
// Assumes: the bus holds mem_err_i meaningful only with mem_rdy_i; the
// register file read port is combinational.
module mreg_xfer_seq #(
    parameter int          NREG     = 16,
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] CTL_ADDR = 32'hE000_E008,
    localparam int         IW       = $clog2(NREG),
    localparam int         PW       = IW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            resume_i,
    input  logic            cont_mode_i,
    input  logic            is_load_i,
    input  logic            wb_en_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [IW-1:0]   base_reg_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            fault_o,
    output logic            brk_o,
    output logic            cont_vld_o,
    output logic [IW-1:0]   cont_idx_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_rdy_i,
    input  logic            mem_err_i,
    output logic [IW-1:0]   rf_raddr_o,
    input  logic [DW-1:0]   rf_rdata_i,
    output logic            rf_we_o,
    output logic [IW-1:0]   rf_waddr_o,
    output logic [DW-1:0]   rf_wdata_o,
    input  logic            irq_req_i,
    output logic            irq_ack_o,
    input  logic            ctl_we_i,
    input  logic            ctl_priv_i,
    input  logic [AW-1:0]   ctl_addr_i,
    input  logic [DW-1:0]   ctl_wdata_i,
    output logic [DW-1:0]   ctl_rdata_o
);
    import mxs_pkg::*;

    mxs_state_e      state_q;
    logic [AW-1:0]   base_q;
    logic [NREG-1:0] mask_q;
    logic            ld_q;
    logic            wb_q;
    logic            mode_q;
    logic [IW-1:0]   breg_q;
    logic [PW-1:0]   ptr_q;
    logic [PW-1:0]   cnt_q;
    logic [IW-1:0]   cur_q;
    logic            cont_vld_q;
    logic [IW-1:0]   cont_idx_q;

    logic [IW-1:0]   nxt_idx;
    logic            nxt_found;
    logic [PW-1:0]   resume_cnt;
    logic            ctl_dis;
    logic            use_cont;
    logic            hs;
    logic [AW-1:0]   seq_addr;

    // next register to move, scanning the latched mask from the pointer
    mxs_find_next #(.NREG(NREG)) u_next (
        .mask  (mask_q),
        .from  (ptr_q),
        .idx   (nxt_idx),
        .found (nxt_found)
    );

    // words already moved before the saved continuation index
    mxs_count_below #(.NREG(NREG)) u_below (
        .mask (mask_i),
        .lim  ({1'b0, cont_idx_q}),
        .cnt  (resume_cnt)
    );

    // interruption-disable control register
    mxs_ctl_reg #(.AW(AW), .DW(DW), .CTL_ADDR(CTL_ADDR)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we_i),
        .priv  (ctl_priv_i),
        .addr  (ctl_addr_i),
        .wdata (ctl_wdata_i),
        .rdata (ctl_rdata_o),
        .dis   (ctl_dis)
    );

    assign use_cont = resume_i && cont_vld_q;
    assign seq_addr = base_q + AW'({cnt_q, 2'b00});
    assign hs       = (state_q == ST_BUS) && mem_rdy_i;

    // status and handshake outputs decoded from the state
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        brk_o     = (state_q == ST_BOUND) && nxt_found && irq_req_i && !ctl_dis;
        irq_ack_o = ((state_q == ST_IDLE) && irq_req_i) || brk_o;
        done_o    = ((state_q == ST_BOUND) && !nxt_found && !wb_q)
                    || (state_q == ST_WRB);
        fault_o   = hs && mem_err_i;
    end

    // bus and register-file port drive
    always_comb begin
        mem_req_o   = (state_q == ST_BUS);
        mem_we_o    = (state_q == ST_BUS) && !ld_q;
        mem_addr_o  = seq_addr;
        mem_wdata_o = rf_rdata_i;
        rf_raddr_o  = cur_q;
        rf_we_o     = (hs && !mem_err_i && ld_q) || (state_q == ST_WRB);
        rf_waddr_o  = (state_q == ST_WRB) ? breg_q : cur_q;
        rf_wdata_o  = (state_q == ST_WRB) ? seq_addr : mem_rdata_i;
    end

    assign cont_vld_o = cont_vld_q;
    assign cont_idx_o = cont_idx_q;

    // sequencing state machine and its operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            mask_q     <= '0;
            ld_q       <= 1'b0;
            wb_q       <= 1'b0;
            mode_q     <= 1'b0;
            breg_q     <= '0;
            ptr_q      <= '0;
            cnt_q      <= '0;
            cur_q      <= '0;
            cont_vld_q <= 1'b0;
            cont_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && !irq_req_i) begin
                        base_q     <= base_i;
                        mask_q     <= mask_i;
                        ld_q       <= is_load_i;
                        wb_q       <= wb_en_i;
                        mode_q     <= cont_mode_i;
                        breg_q     <= base_reg_i;
                        ptr_q      <= use_cont ? {1'b0, cont_idx_q} : '0;
                        cnt_q      <= use_cont ? resume_cnt : '0;
                        cont_vld_q <= 1'b0;
                        state_q    <= ST_BOUND;
                    end
                end
                ST_BOUND: begin
                    if (!nxt_found) begin
                        state_q <= wb_q ? ST_WRB : ST_IDLE;
                    end else if (brk_o) begin
                        cont_vld_q <= mode_q;
                        cont_idx_q <= nxt_idx;
                        state_q    <= ST_IDLE;
                    end else begin
                        cur_q   <= nxt_idx;
                        state_q <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (hs) begin
                        if (mem_err_i) begin
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q   <= cnt_q + PW'(1);
                            ptr_q   <= PW'(cur_q) + PW'(1);
                            state_q <= ST_BOUND;
                        end
                    end
                end
                ST_WRB: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mxs_chk.sv
// Module: property checker for the sequencer, attached by bind.
// Assumes: sampled on the rising clock; all checks idle in reset.
module mxs_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          fault,
    input logic          brk,
    input logic          irq_ack,
    input logic          mem_req,
    input logic          mem_rdy,
    input logic [AW-1:0] mem_addr,
    input logic          rf_we,
    input logic          cont_vld,
    input logic          ctl_dis
);
    // R10: acknowledge only with no outstanding bus access
    a_r10_ack_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !mem_req);

    // R11: completion is exclusive with break and fault
    a_r11_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!brk && !fault));

    // R1: a stalled request keeps its address
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

    // R8: disable bit suppresses acknowledge while busy
    a_r8_dis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_dis && busy) |-> !irq_ack);

    // R3: a break leaves the block idle next cycle
    a_r3_brk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !busy);

    // R6: a fault writes no register and ends with no continuation
    a_r6_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !rf_we);
    a_r6_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!busy && !cont_vld));
endmodule

bind mreg_xfer_seq mxs_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_o),
    .done     (done_o),
    .fault    (fault_o),
    .brk      (brk_o),
    .irq_ack  (irq_ack_o),
    .mem_req  (mem_req_o),
    .mem_rdy  (mem_rdy_i),
    .mem_addr (mem_addr_o),
    .rf_we    (rf_we_o),
    .cont_vld (cont_vld_o),
    .ctl_dis  (ctl_dis)
);

// File: tb/mreg_xfer_seq_test.sv
`timescale 1ns/1ps
// Bench: table-driven sequences followed by directed interrupt, fault,
// control-register and reset tests. Memory and register file are modelled.
module mreg_xfer_seq_test;
    localparam logic [31:0] RF_PAT  = 32'hA000_0000;
    localparam logic [31:0] MEM_PAT = 32'h5000_0000;
    localparam logic [31:0] CADDR   = 32'hE000_E008;

    typedef struct packed {
        logic [15:0] mask;
        logic [5:0]  boff;
        logic        ld;
        logic        wb;
        logic [3:0]  breg;
        logic [1:0]  lat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h00A6, 6'd4,  1'b1, 1'b1, 4'd0,  2'd0},
        '{16'hFFFF, 6'd8,  1'b0, 1'b1, 4'd0,  2'd1},
        '{16'h8001, 6'd20, 1'b1, 1'b0, 4'd3,  2'd2},
        '{16'h0F0F, 6'd30, 1'b0, 1'b0, 4'd5,  2'd3},
        '{16'h4210, 6'd40, 1'b1, 1'b1, 4'd15, 2'd1},
        '{16'h0000, 6'd12, 1'b1, 1'b1, 4'd7,  2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, resume_i = 1'b0, cont_mode_i = 1'b1;
    logic is_load_i = 1'b0, wb_en_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic [3:0]  base_reg_i = '0;
    logic busy_o, done_o, fault_o, brk_o, cont_vld_o;
    logic [3:0] cont_idx_o;
    logic mem_req_o, mem_we_o, mem_rdy_i, mem_err_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0] rf_raddr_o, rf_waddr_o;
    logic [31:0] rf_rdata_i, rf_wdata_o;
    logic rf_we_o;
    logic irq_req_i = 1'b0, irq_ack_o;
    logic ctl_we_i = 1'b0, ctl_priv_i = 1'b0;
    logic [31:0] ctl_addr_i = '0, ctl_wdata_i = '0, ctl_rdata_o;

    logic [31:0] rf  [16];
    logic [31:0] mem [64];
    logic [31:0] trace [16];
    logic [7:0]  tcnt;
    logic [3:0]  wcnt;
    logic [1:0]  lat = 2'd0;
    logic        init_req = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mreg_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
        .cont_mode_i(cont_mode_i), .is_load_i(is_load_i), .wb_en_i(wb_en_i),
        .base_i(base_i), .mask_i(mask_i), .base_reg_i(base_reg_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .brk_o(brk_o),
        .cont_vld_o(cont_vld_o), .cont_idx_o(cont_idx_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_rdy_i(mem_rdy_i), .mem_err_i(mem_err_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .irq_req_i(irq_req_i), .irq_ack_o(irq_ack_o),
        .ctl_we_i(ctl_we_i), .ctl_priv_i(ctl_priv_i), .ctl_addr_i(ctl_addr_i),
        .ctl_wdata_i(ctl_wdata_i), .ctl_rdata_o(ctl_rdata_o)
    );

    assign mem_rdy_i   = mem_req_o && (wcnt >= {2'b00, lat});
    assign mem_err_i   = mem_rdy_i && err_en && (mem_addr_o == err_addr);
    assign mem_rdata_i = mem[mem_addr_o[7:2]];
    assign rf_rdata_i  = rf[rf_raddr_o];

    // memory, register file, wait-state and transfer-trace models
    always @(posedge clk) begin
        if (mem_req_o && !mem_rdy_i) wcnt <= wcnt + 4'd1;
        else wcnt <= 4'd0;
        if (init_req) begin
            for (int i = 0; i < 16; i++) rf[i] <= RF_PAT + 32'(i);
            for (int i = 0; i < 64; i++) mem[i] <= MEM_PAT + 32'(i);
            tcnt <= 8'd0;
        end else begin
            if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
            if (mem_rdy_i && !mem_err_i) begin
                trace[tcnt[3:0]] <= mem_addr_o;
                tcnt <= tcnt + 8'd1;
                if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
            end
        end
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic init_models();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    task automatic launch(input logic [15:0] m, input logic [31:0] b,
                          input logic ld, input logic wb, input logic [3:0] br,
                          input logic res, input logic mode);
        @(negedge clk);
        mask_i = m; base_i = b; is_load_i = ld; wb_en_i = wb;
        base_reg_i = br; resume_i = res; cont_mode_i = mode; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_end(output bit d, output bit f, output bit b,
                            output bit ack_busy);
        bit seen = 0;
        d = 0; f = 0; b = 0; ack_busy = 0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (irq_ack_o && busy_o && !brk_o) ack_busy = 1;
            if (done_o || fault_o || brk_o) begin
                d = done_o; f = fault_o; b = brk_o; seen = 1;
            end else begin
                @(negedge clk);
            end
        end
        if (!seen) chk(0, "R11", "sequence end timeout", 0, 1);
    endtask

    task automatic ctl_write(input logic priv, input logic [31:0] a,
                             input logic [31:0] v);
        @(negedge clk);
        ctl_we_i = 1'b1; ctl_priv_i = priv; ctl_addr_i = a; ctl_wdata_i = v;
        @(negedge clk);
        ctl_we_i = 1'b0; ctl_priv_i = 1'b1; ctl_addr_i = CADDR;
        #1;
    endtask

    function automatic int popc(input logic [15:0] m);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return n;
    endfunction

    initial begin
        bit d, f, b, ab;
        logic [31:0] bb;
        int bw, k, bad;

        // reset state (R9, R11)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ctl_priv_i = 1'b1; ctl_addr_i = CADDR;
        @(negedge clk);
        chk(!busy_o && !done_o && !cont_vld_o && !mem_req_o, "R11",
            "idle after reset", {busy_o, done_o, cont_vld_o, mem_req_o}, 0);
        chk(ctl_rdata_o == 0, "R9", "control resets to 0", ctl_rdata_o, 0);

        // table-driven sequences (R1, R2, R7, R11, R12)
        for (int v = 0; v < 6; v++) begin
            init_models();
            lat = VECS[v].lat;
            bw  = int'(VECS[v].boff);
            bb  = 32'(bw) * 4;
            launch(VECS[v].mask, bb, VECS[v].ld, VECS[v].wb, VECS[v].breg,
                   1'b0, 1'b1);
            wait_end(d, f, b, ab);
            @(negedge clk);
            chk(d && !f && !b, "R11", "completes with done only",
                {29'd0, d, f, b}, 32'h4);
            chk(int'(tcnt) == popc(VECS[v].mask), "R12", "word count",
                32'(tcnt), 32'(popc(VECS[v].mask)));
            k = 0; bad = 0;
            for (int r = 0; r < 16; r++) begin
                if (VECS[v].mask[r]) begin
                    if (trace[k] != bb + 32'(4 * k)) bad++;
                    if (VECS[v].ld && rf[r] != MEM_PAT + 32'(bw + k)) bad++;
                    if (!VECS[v].ld && mem[bw + k] != RF_PAT + 32'(r)) bad++;
                    k++;
                end
            end
            chk(bad == 0, "R1", "address order and data (R2)", 32'(bad), 0);
            if (VECS[v].wb)
                chk(rf[VECS[v].breg] == bb + 32'(4 * popc(VECS[v].mask)), "R7",
                    "base writeback", rf[VECS[v].breg],
                    bb + 32'(4 * popc(VECS[v].mask)));
            else
                chk(rf[VECS[v].breg] == RF_PAT + 32'(VECS[v].breg), "R7",
                    "base unchanged without flag", rf[VECS[v].breg],
                    RF_PAT + 32'(VECS[v].breg));
        end

        // continuation mode break and resume (R3, R4, R10)
        init_models();
        lat = 2'd0; bw = 10; bb = 32'd40;
        launch(16'h00A6, bb, 1'b1, 1'b0, 4'd9, 1'b0, 1'b1);
        for (int t = 0; t < 100 && tcnt != 8'd2; t++) @(negedge clk);
        irq_req_i = 1'b1;
        #1;
        chk(brk_o && irq_ack_o && !mem_req_o, "R10", "break acked without bus",
            {29'd0, brk_o, irq_ack_o, mem_req_o}, 32'h6);
        @(negedge clk);
        irq_req_i = 1'b0;
        chk(!busy_o && !done_o, "R3", "break ends sequence without done",
            {30'd0, busy_o, done_o}, 0);
        chk(cont_vld_o && cont_idx_o == 4'd5, "R4", "continuation index",
            {27'd0, cont_vld_o, cont_idx_o}, 32'h15);
        launch(16'h00A6, bb, 1'b1, 1'b0, 4'd9, 1'b1, 1'b1);
        wait_end(d, f, b, ab);
        @(negedge clk);
        chk(d && tcnt == 8'd4 && trace[2] == bb + 8 && trace[3] == bb + 12,
            "R4", "resume addresses", trace[2], bb + 8);
        chk(rf[5] == MEM_PAT + 32'(bw + 2) && rf[7] == MEM_PAT + 32'(bw + 3),
            "R4", "resumed load data", rf[7], MEM_PAT + 32'(bw + 3));

        // restart mode break and replay (R5)
        init_models();
        launch(16'h00A6, bb, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0);
        for (int t = 0; t < 100 && tcnt != 8'd2; t++) @(negedge clk);
        irq_req_i = 1'b1;
        @(negedge clk);
        irq_req_i = 1'b0;
        chk(!busy_o && !cont_vld_o, "R5", "no continuation kept",
            {30'd0, busy_o, cont_vld_o}, 0);
        launch(16'h00A6, bb, 1'b1, 1'b0, 4'd9, 1'b1, 1'b0);
        wait_end(d, f, b, ab);
        @(negedge clk);
        chk(d && tcnt == 8'd6 && trace[2] == bb && trace[5] == bb + 12, "R5",
            "replay from first register", trace[2], bb);

        // fault on second store word (R6)
        init_models();
        err_en = 1'b1; err_addr = bb + 4;
        launch(16'h0007, bb, 1'b0, 1'b1, 4'd9, 1'b0, 1'b1);
        wait_end(d, f, b, ab);
        chk(f && !d, "R6", "fault reported", {30'd0, f, d}, 32'h2);
        @(negedge clk);
        err_en = 1'b0;
        chk(!busy_o && tcnt == 8'd1, "R6", "stops after fault", 32'(tcnt), 1);
        chk(rf[9] == RF_PAT + 9, "R6", "base not written", rf[9], RF_PAT + 9);
        chk(mem[bw + 1] == MEM_PAT + 32'(bw + 1), "R6", "faulting store no effect",
            mem[bw + 1], MEM_PAT + 32'(bw + 1));

        // control register access rules (R9)
        ctl_write(1'b0, CADDR, 32'h1);
        chk(ctl_rdata_o == 0, "R9", "unprivileged write ignored", ctl_rdata_o, 0);
        ctl_write(1'b1, CADDR + 4, 32'h1);
        chk(ctl_rdata_o == 0, "R9", "other address ignored", ctl_rdata_o, 0);
        ctl_write(1'b1, CADDR, 32'hFFFF_FFFF);
        chk(ctl_rdata_o == 32'h1, "R9", "only bit 0 reads back", ctl_rdata_o, 1);

        // disable bit forces completion (R8)
        init_models();
        lat = 2'd1;
        launch(16'h00A6, bb, 1'b1, 1'b0, 4'd9, 1'b0, 1'b1);
        irq_req_i = 1'b1;
        wait_end(d, f, b, ab);
        chk(d && !b && !ab && !irq_ack_o, "R8", "no ack while busy",
            {29'd0, ab, b, irq_ack_o}, 0);
        @(negedge clk);
        chk(tcnt == 8'd4 && irq_ack_o, "R8", "all words then ack when idle",
            32'(tcnt), 4);
        irq_req_i = 1'b0;
        ctl_write(1'b1, CADDR, 32'h0);
        chk(ctl_rdata_o == 0, "R9", "privileged clear", ctl_rdata_o, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule